// File: doc/BRIEF.md
# Width-Adapting Peripheral Bus Bridge

The bridge sits between a 32-bit CPU-side register bus and two peripheral register ports of different widths: a 16-bit port and a 32-bit-only port. Each CPU access carries a byte offset, an access size (byte, halfword or word), a direction and write data. A select input picks which port the access goes to; choosing between peripherals by address is left to the surrounding logic.

On the 16-bit port a word access turns into two halfword transactions. The lower half goes first at the given offset and the upper half follows at offset+2. Byte and halfword accesses pass through as one transaction. On the 32-bit port the offset is aligned down to a word address. Write data is moved onto the addressed byte lanes, and byte enables are generated for those lanes. Read data coming back from either port is cut to the requested size and zero-extended. The CPU gets a one-cycle completion pulse carrying the read data. It can then issue the next request in that same cycle.

Top module: `pbus_bridge`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `hp_valid` and `wp_valid` are 0.
- R2: `req_wide`=0 selects the 16-bit port and `req_wide`=1 the 32-bit port. On the 16-bit port a word read (`req_size`=2) issues two halfword reads, first at the offset and then at offset+2. The first result becomes bits 15:0 and the second becomes bits 31:16.
- R3: On the 16-bit port a word write issues write data bits 15:0 at the offset first, then bits 31:16 at offset+2.
- R4: On the 16-bit port a byte (`req_size`=0) or halfword (`req_size`=1) access is a single transaction, with `hp_half`=1 for halfword and 0 for byte. Its write data is the CPU data zero-extended from the access size and cut to 16 bits. Its read data is zero-extended.
- R5: On the 32-bit port `wp_addr` is the offset with bits 1:0 cleared. Read data is taken from the register word without any lane shift.
- R6: On the 32-bit port, write data is the CPU data zero-extended from the access size and then shifted left by 8 times offset[1:0]. `wp_be` is 4'b0001<<offset[1:0] for a byte and 4'b0011<<offset[1:0] for a halfword, with lanes above 3 dropped. It is 4'b1111 for a word.
- R7: A byte read returns bits 7:0 of the port result and a halfword read returns bits 15:0, with the upper bits of `rsp_rdata` at 0. A word read returns all 32 bits.
- R8: `rsp_valid` pulses for one cycle, in the cycle after the final port acknowledge. A split word completes only after both halves are acknowledged. `req_ready` is 0 from acceptance until the response cycle.
- R9: A port's valid, offset and write data stay stable until that port acknowledges.
- R10: `req_ready` is 1 in the cycle in which `rsp_valid` is 1, so a new request can be accepted in the same cycle the previous completion is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit port, 0 = 16-bit port |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_offset | input | OFS_W | Byte offset |
| req_wdata | input | 32 | CPU write data |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Sized read data |
| hp_valid | output | 1 | 16-bit port transaction present |
| hp_write | output | 1 | 16-bit port direction |
| hp_half | output | 1 | 1 = halfword, 0 = byte |
| hp_offset | output | OFS_W | 16-bit port byte offset |
| hp_wdata | output | 16 | 16-bit port write data |
| hp_ack | input | 1 | 16-bit port acknowledge |
| hp_rdata | input | 16 | 16-bit port read data, valid with ack |
| wp_valid | output | 1 | 32-bit port transaction present |
| wp_write | output | 1 | 32-bit port direction |
| wp_addr | output | OFS_W | Word-aligned address |
| wp_be | output | 4 | Write byte enables |
| wp_wdata | output | 32 | Lane-shifted write data |
| wp_ack | input | 1 | 32-bit port acknowledge |
| wp_rdata | input | 32 | 32-bit port read data, valid with ack |

## Verification
Two events can fall in the same cycle: the completion of one access on `rsp_valid` and the acceptance of the next request. The bench provokes this by running the peripheral models with zero wait states and driving each new request in the very cycle its predecessor's response appears. It checks that `req_ready` is high there. It also checks that the following access still produces the right port transactions and read data, and that the previous response was not disturbed. Random wait states between 0 and 2 cycles on the port acknowledges also move the final acknowledge of a split word relative to the next request.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int unsigned CPU_W   = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned LANES   = CPU_W / 8;
  localparam int unsigned LANE_IW = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HLO  = 2'd1,
    ST_HHI  = 2'd2,
    ST_WIDE = 2'd3
  } state_e;

  // Zero-extend from the access size; used for write forwarding and read narrowing.
  function automatic logic [CPU_W-1:0] fit_size(size_e sz, logic [CPU_W-1:0] d);
    case (sz)
      SZ_BYTE: return {{(CPU_W-8){1'b0}}, d[7:0]};
      SZ_HALF: return {{(CPU_W-16){1'b0}}, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic is_word(size_e sz);
    return (sz != SZ_BYTE) && (sz != SZ_HALF);
  endfunction

  // Byte enables for the addressed lanes; lanes past the top are dropped.
  function automatic logic [LANES-1:0] lane_mask(size_e sz, logic [LANE_IW-1:0] lo);
    logic [2*LANES-1:0] m;
    case (sz)
      SZ_BYTE: m = {{(2*LANES-1){1'b0}}, 1'b1};
      SZ_HALF: m = {{(2*LANES-2){1'b0}}, 2'b11};
      default: return {LANES{1'b1}};
    endcase
    m = m << lo;
    return m[LANES-1:0];
  endfunction

  function automatic logic [CPU_W-1:0] lane_shift(logic [CPU_W-1:0] d, logic [LANE_IW-1:0] lo);
    return d << {lo, 3'b000};
  endfunction

endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_wide,
  input  logic [1:0]       req_size,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [CPU_W-1:0] req_wdata,
  input  logic             hp_ack,
  input  logic             wp_ack,
  output logic             req_ready,
  output state_e           state,
  output logic             lat_write,
  output size_e            lat_size,
  output logic [OFS_W-1:0] lat_offset,
  output logic [CPU_W-1:0] lat_wdata,
  output logic             acc_evt,
  output logic             split_lo_evt,
  output logic             done_evt
);

  logic lo_ack, hi_ack, wide_ack;

  assign req_ready    = (state == ST_IDLE);
  assign acc_evt      = req_valid && req_ready;
  assign lo_ack       = (state == ST_HLO)  && hp_ack;
  assign hi_ack       = (state == ST_HHI)  && hp_ack;
  assign wide_ack     = (state == ST_WIDE) && wp_ack;
  assign split_lo_evt = lo_ack && is_word(lat_size);
  assign done_evt     = (lo_ack && !is_word(lat_size)) || hi_ack || wide_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      lat_write  <= 1'b0;
      lat_size   <= SZ_BYTE;
      lat_offset <= '0;
      lat_wdata  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (acc_evt) begin
          lat_write  <= req_write;
          lat_size   <= size_e'(req_size);
          lat_offset <= req_offset;
          lat_wdata  <= req_wdata;
          state      <= req_wide ? ST_WIDE : ST_HLO;
        end
        ST_HLO:  if (hp_ack) state <= is_word(lat_size) ? ST_HHI : ST_IDLE;
        ST_HHI:  if (hp_ack) state <= ST_IDLE;
        default: if (wp_ack) state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pbus_hport.sv
module pbus_hport
  import pbus_pkg::*;
#(
  parameter int unsigned OFS_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_e            state,
  input  logic              lat_write,
  input  size_e             lat_size,
  input  logic [OFS_W-1:0]  lat_offset,
  input  logic [CPU_W-1:0]  lat_wdata,
  input  logic              split_lo_evt,
  input  logic [HALF_W-1:0] hp_rdata,
  output logic              hp_valid,
  output logic              hp_write,
  output logic              hp_half,
  output logic [OFS_W-1:0]  hp_offset,
  output logic [HALF_W-1:0] hp_wdata,
  output logic [CPU_W-1:0]  half_rdata
);

  localparam logic [OFS_W-1:0] HI_STEP = OFS_W'(HALF_W / 8);

  logic [CPU_W-1:0]  wext;
  logic [HALF_W-1:0] lo_q;
  logic              upper;

  assign upper     = (state == ST_HHI);
  assign wext      = fit_size(lat_size, lat_wdata);
  assign hp_valid  = (state == ST_HLO) || upper;
  assign hp_write  = lat_write;
  assign hp_half   = (lat_size != SZ_BYTE);
  assign hp_offset = upper ? lat_offset + HI_STEP : lat_offset;
  assign hp_wdata  = upper ? wext[CPU_W-1:HALF_W] : wext[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)            lo_q <= '0;
    else if (split_lo_evt) lo_q <= hp_rdata;
  end

  assign half_rdata = is_word(lat_size) ? {hp_rdata, lo_q}
                                        : {{(CPU_W-HALF_W){1'b0}}, hp_rdata};

endmodule

// File: rtl/pbus_wport.sv
module pbus_wport
  import pbus_pkg::*;
#(
  parameter int unsigned OFS_W = 12
) (
  input  state_e            state,
  input  logic              lat_write,
  input  size_e             lat_size,
  input  logic [OFS_W-1:0]  lat_offset,
  input  logic [CPU_W-1:0]  lat_wdata,
  output logic              wp_valid,
  output logic              wp_write,
  output logic [OFS_W-1:0]  wp_addr,
  output logic [LANES-1:0]  wp_be,
  output logic [CPU_W-1:0]  wp_wdata
);

  logic [LANE_IW-1:0] lo;

  assign lo       = lat_offset[LANE_IW-1:0];
  assign wp_valid = (state == ST_WIDE);
  assign wp_write = lat_write;
  assign wp_addr  = {lat_offset[OFS_W-1:LANE_IW], {LANE_IW{1'b0}}};
  assign wp_be    = lane_mask(lat_size, lo);
  assign wp_wdata = lane_shift(fit_size(lat_size, lat_wdata), lo);

endmodule

// File: rtl/pbus_rsp.sv
module pbus_rsp
  import pbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_evt,
  input  state_e           state,
  input  size_e            lat_size,
  input  logic [CPU_W-1:0] half_rdata,
  input  logic [CPU_W-1:0] wp_rdata,
  output logic             rsp_valid,
  output logic [CPU_W-1:0] rsp_rdata
);

  logic [CPU_W-1:0] raw;

  assign raw = (state == ST_WIDE) ? wp_rdata : half_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= done_evt;
      if (done_evt) rsp_rdata <= fit_size(lat_size, raw);
    end
  end

endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbus_pkg::*;
#(
  parameter int unsigned OFS_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [1:0]        req_size,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              hp_valid,
  output logic              hp_write,
  output logic              hp_half,
  output logic [OFS_W-1:0]  hp_offset,
  output logic [15:0]       hp_wdata,
  input  logic              hp_ack,
  input  logic [15:0]       hp_rdata,
  output logic              wp_valid,
  output logic              wp_write,
  output logic [OFS_W-1:0]  wp_addr,
  output logic [3:0]        wp_be,
  output logic [31:0]       wp_wdata,
  input  logic              wp_ack,
  input  logic [31:0]       wp_rdata
);

  state_e           state;
  logic             lat_write;
  size_e            lat_size;
  logic [OFS_W-1:0] lat_offset;
  logic [CPU_W-1:0] lat_wdata;
  logic             acc_evt;
  logic             split_lo_evt;
  logic             done_evt;
  logic [CPU_W-1:0] half_rdata;

  pbus_seq #(.OFS_W(OFS_W)) u_seq (
    .clk, .rst_n, .req_valid, .req_write, .req_wide, .req_size, .req_offset,
    .req_wdata, .hp_ack, .wp_ack, .req_ready, .state, .lat_write, .lat_size,
    .lat_offset, .lat_wdata, .acc_evt, .split_lo_evt, .done_evt
  );

  pbus_hport #(.OFS_W(OFS_W)) u_hport (
    .clk, .rst_n, .state, .lat_write, .lat_size, .lat_offset, .lat_wdata,
    .split_lo_evt, .hp_rdata, .hp_valid, .hp_write, .hp_half, .hp_offset,
    .hp_wdata, .half_rdata
  );

  pbus_wport #(.OFS_W(OFS_W)) u_wport (
    .state, .lat_write, .lat_size, .lat_offset, .lat_wdata,
    .wp_valid, .wp_write, .wp_addr, .wp_be, .wp_wdata
  );

  pbus_rsp u_rsp (
    .clk, .rst_n, .done_evt, .state, .lat_size, .half_rdata, .wp_rdata,
    .rsp_valid, .rsp_rdata
  );

endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk
  import pbus_pkg::*;
#(
  parameter int unsigned OFS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_evt,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic             hp_valid,
  input logic             hp_ack,
  input logic             hp_half,
  input logic [OFS_W-1:0] hp_offset,
  input logic [15:0]      hp_wdata,
  input logic             wp_valid,
  input logic             wp_ack,
  input logic [OFS_W-1:0] wp_addr,
  input logic [3:0]       wp_be,
  input logic [31:0]      wp_wdata,
  input logic             split_lo_evt,
  input size_e            lat_size
);

  // R8
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_valid || wp_valid || acc_evt) |=> !req_ready || rsp_valid);

  // R9
  hp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_valid && !hp_ack) |=> hp_valid && $stable(hp_offset) && $stable(hp_wdata));

  // R9
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_valid && !wp_ack) |=> wp_valid && $stable(wp_addr) && $stable(wp_wdata) && $stable(wp_be));

  // R5
  wp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_valid |-> (wp_addr[1:0] == 2'b00));

  // R2
  split_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_lo_evt |=> hp_valid && hp_half && (hp_offset == $past(hp_offset) + OFS_W'(2)));

  // R8
  rsp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past((hp_valid && hp_ack) || (wp_valid && wp_ack)));

  // R7
  byte_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && lat_size == SZ_BYTE) |-> (rsp_rdata[31:8] == 24'h0));

  // R7
  half_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && lat_size == SZ_HALF) |-> (rsp_rdata[31:16] == 16'h0));

  // R6
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_valid && lat_size == SZ_BYTE) |-> ($countones(wp_be) == 1));

  // R10
  rsp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

endmodule

bind pbus_bridge pbus_bridge_chk #(.OFS_W(OFS_W)) u_chk (.*);

// File: tb/pbus_bridge_tb.sv
`timescale 1ns/1ps
module pbus_bridge_tb;

  localparam int OFS_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             req_valid = 0, req_write = 0, req_wide = 0;
  logic [1:0]       req_size = 0;
  logic [OFS_W-1:0] req_offset = 0;
  logic [31:0]      req_wdata = 0;
  logic             req_ready, rsp_valid;
  logic [31:0]      rsp_rdata;
  logic             hp_valid, hp_write, hp_half;
  logic [OFS_W-1:0] hp_offset;
  logic [15:0]      hp_wdata;
  logic             hp_ack = 0;
  logic [15:0]      hp_rdata = 0;
  logic             wp_valid, wp_write;
  logic [OFS_W-1:0] wp_addr;
  logic [3:0]       wp_be;
  logic [31:0]      wp_wdata;
  logic             wp_ack = 0;
  logic [31:0]      wp_rdata = 0;

  pbus_bridge #(.OFS_W(OFS_W)) u_dut (.*);

  int tests = 0, fails = 0;
  bit zero_wait = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- peripheral models ----------------
  logic [15:0] hmem [128];
  logic [31:0] wmem [64];
  logic [7:0]  hlog_off [8];
  logic [15:0] hlog_dat [8];
  logic        hlog_half [8];
  int          hn = 0;
  logic [7:0]  wlog_addr;
  logic [3:0]  wlog_be;
  logic [31:0] wlog_dat;
  int          wn = 0;
  int          hwait = 0, wwait = 0;
  int          hold_err = 0;
  logic [7:0]  h_first_off;
  logic [15:0] h_first_dat;
  bit          h_waiting = 0;

  initial begin
    for (int i = 0; i < 128; i++) hmem[i] = 16'h0;
    for (int i = 0; i < 64; i++) wmem[i] = 32'h0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      hp_ack = 0; hwait = 0; h_waiting = 0;
    end else if (hp_ack) begin
      hp_ack = 0;
      hwait = zero_wait ? 0 : int'($urandom % 3);
    end else if (hp_valid) begin
      if (h_waiting && (hp_offset[7:0] !== h_first_off || hp_wdata !== h_first_dat)) hold_err++;
      if (hwait == 0) begin
        h_waiting = 0;
        hlog_off[hn % 8] = hp_offset[7:0];
        hlog_dat[hn % 8] = hp_wdata;
        hlog_half[hn % 8] = hp_half;
        hn++;
        if (hp_write) begin
          if (hp_half) hmem[hp_offset[7:1]] = hp_wdata;
          else if (hp_offset[0]) hmem[hp_offset[7:1]][15:8] = hp_wdata[7:0];
          else hmem[hp_offset[7:1]][7:0] = hp_wdata[7:0];
        end
        hp_rdata = (!hp_half && hp_offset[0]) ? {8'h0, hmem[hp_offset[7:1]][15:8]}
                                              : hmem[hp_offset[7:1]];
        hp_ack = 1;
      end else begin
        if (!h_waiting) begin h_first_off = hp_offset[7:0]; h_first_dat = hp_wdata; end
        h_waiting = 1;
        hwait--;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      wp_ack = 0; wwait = 0;
    end else if (wp_ack) begin
      wp_ack = 0;
      wwait = zero_wait ? 0 : int'($urandom % 3);
    end else if (wp_valid) begin
      if (wwait == 0) begin
        wlog_addr = wp_addr[7:0]; wlog_be = wp_be; wlog_dat = wp_wdata; wn++;
        if (wp_write)
          for (int b = 0; b < 4; b++)
            if (wp_be[b]) wmem[wp_addr[7:2]][8*b +: 8] = wp_wdata[8*b +: 8];
        wp_rdata = wmem[wp_addr[7:2]];
        wp_ack = 1;
      end else wwait--;
    end
  end

  // ---------------- bench-side expectations ----------------
  logic [15:0] hm [128];
  logic [31:0] wm [64];
  initial begin
    for (int i = 0; i < 128; i++) hm[i] = 16'h0;
    for (int i = 0; i < 64; i++) wm[i] = 32'h0;
  end

  function automatic logic [31:0] exp_narrow(logic [1:0] sz, logic [31:0] d);
    logic [31:0] m;
    m = (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    return d & m;
  endfunction

  function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] lo);
    logic [3:0] be = 4'h0;
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    int start = (sz == 2'd2) ? 0 : int'(lo);
    for (int i = 0; i < 4; i++) if (i >= start && i < start + n) be[i] = 1'b1;
    return be;
  endfunction

  function automatic logic [31:0] exp_lane_data(logic [1:0] sz, logic [1:0] lo, logic [31:0] d);
    logic [31:0] n = exp_narrow(sz, d);
    logic [31:0] r = 32'h0;
    for (int i = 0; i < 4; i++)
      if (i >= int'(lo)) r[8*i +: 8] = n[8*(i - int'(lo)) +: 8];
    return r;
  endfunction

  task automatic run_op(bit wide, bit wr, logic [1:0] sz, logic [7:0] off, logic [31:0] wd);
    int h0 = hn;
    int w0 = wn;
    logic [31:0] rd, exp;
    logic [6:0] hi;
    logic [5:0] wi;
    logic [3:0] be;
    logic [31:0] ld;
    if (rsp_valid) check("R10 ready in response cycle", {31'h0, req_ready}, 32'h1);
    req_valid = 1; req_write = wr; req_wide = wide; req_size = sz;
    req_offset = {4'h0, off}; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R8 busy after accept", {31'h0, req_ready}, 32'h0);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    hi = off[7:1];
    wi = off[7:2];
    if (!wide) begin
      if (sz == 2'd2) begin
        check("R8 split done after two halves", 32'(hn - h0), 32'd2);
        check("R2/R3 first half offset", {24'h0, hlog_off[h0 % 8]}, {24'h0, off});
        check("R2/R3 second half offset", {24'h0, hlog_off[(h0 + 1) % 8]}, {24'h0, off + 8'd2});
        if (wr) begin
          check("R3 low half data", {16'h0, hlog_dat[h0 % 8]}, {16'h0, wd[15:0]});
          check("R3 high half data", {16'h0, hlog_dat[(h0 + 1) % 8]}, {16'h0, wd[31:16]});
          hm[hi] = wd[15:0]; hm[hi + 7'd1] = wd[31:16];
        end else check("R2 word read", rd, {hm[hi + 7'd1], hm[hi]});
      end else begin
        check("R4 single transaction", 32'(hn - h0), 32'd1);
        check("R4 size flag", {31'h0, hlog_half[h0 % 8]}, {31'h0, sz == 2'd1});
        if (wr) begin
          check("R4 write data", {16'h0, hlog_dat[h0 % 8]}, exp_narrow(sz, wd));
          if (sz == 2'd1) hm[hi] = wd[15:0];
          else if (off[0]) hm[hi][15:8] = wd[7:0];
          else hm[hi][7:0] = wd[7:0];
        end else begin
          exp = (sz == 2'd1) ? {16'h0, hm[hi]} : (off[0] ? {24'h0, hm[hi][15:8]} : {24'h0, hm[hi][7:0]});
          check(sz == 2'd1 ? "R4/R7 half read" : "R4/R7 byte read", rd, exp);
        end
      end
    end else begin
      check("R8 one wide transaction", 32'(wn - w0), 32'd1);
      check("R5 aligned address", {24'h0, wlog_addr}, {24'h0, off & 8'hFC});
      if (wr) begin
        be = exp_be(sz, off[1:0]);
        ld = exp_lane_data(sz, off[1:0], wd);
        check("R6 byte enables", {28'h0, wlog_be}, {28'h0, be});
        check("R6 shifted write data", wlog_dat, ld);
        for (int b = 0; b < 4; b++) if (be[b]) wm[wi][8*b +: 8] = ld[8*b +: 8];
      end else check("R5/R7 wide read", rd, exp_narrow(sz, wm[wi]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1 ready at reset", {31'h0, req_ready}, 32'h1);
    check("R1 no response at reset", {31'h0, rsp_valid}, 32'h0);
    check("R1 ports idle at reset", {30'h0, hp_valid, wp_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // Directed corners, zero wait states, back-to-back issue (R10)
    zero_wait = 1;
    run_op(1, 1, 2'd0, 8'h03, 32'h1234_56AB);
    run_op(1, 1, 2'd1, 8'h02, 32'hFFFF_BEEF);
    run_op(1, 1, 2'd1, 8'h07, 32'h0000_5A3C);
    run_op(1, 1, 2'd2, 8'h09, 32'hCAFE_F00D);
    run_op(1, 0, 2'd0, 8'h03, 32'h0);
    run_op(1, 0, 2'd1, 8'h02, 32'h0);
    run_op(1, 0, 2'd2, 8'h08, 32'h0);
    run_op(0, 1, 2'd2, 8'hFC, 32'hA5A5_1357);
    run_op(0, 0, 2'd2, 8'hFC, 32'h0);
    run_op(0, 1, 2'd0, 8'h11, 32'hFFFF_FF77);
    run_op(0, 0, 2'd0, 8'h11, 32'h0);
    run_op(0, 0, 2'd1, 8'h10, 32'h0);
    run_op(0, 1, 2'd2, 8'h00, 32'h8001_7FFE);
    run_op(0, 0, 2'd2, 8'h00, 32'h0);

    // Constrained random
    zero_wait = 0;
    for (int n = 0; n < 400; n++) begin
      bit w = $urandom % 2;
      bit wr = $urandom % 2;
      logic [1:0] sz = 2'($urandom % 3);
      logic [7:0] off;
      if (!w && sz != 2'd0) off = 8'(($urandom % 127) * 2);
      else off = 8'($urandom % 256);
      if ($urandom % 4 == 0) repeat ($urandom % 3 + 1) @(negedge clk);
      run_op(w, wr, sz, off, $urandom);
    end

    @(negedge clk);
    check("R9 port fields held while waiting", 32'(hold_err), 32'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule